// File: doc/BRIEF.md
# Link recovery rate-change sequencer

This block is the control core that moves a serial link out of its active state, through the recovery substates, and back again so that the link runs at a new data rate. Other logic decodes the received training sets and presents their fields. This block decides which ordered set the transmitter sends next and which control bits go into it. It also decides when the lane logic switches to the new rate and when the change counts as finished. Symbol handling on the lanes and the equalization algorithm are outside the block. It sees only a lock indication, an electrical-idle-done indication and an equalization-done indication.

A change takes two passes through the lock and configuration substates. The first pass runs at the old rate and announces the change: the speed-change bit is set and the wanted rate is advertised. Next comes a switch substate. The transmitter sends an electrical-idle ordered set, and the rate flips once the lanes report that idle is complete. The second pass runs at the new rate with the change bits cleared. The first time the link lands on a 128b/130b rate, an equalization detour is added to the second pass. A per-rate ledger, cleared at reset, decides whether that detour is needed.

Each recovery substate has a dwell limit. If a substate lasts too long, the block restores the previous rate, returns to active and reports a failure. A successful change gives a one-cycle completion pulse, tagged with whether the change was autonomous.

Top module: `rate_recovery_seq`

## Requirements
- R1: After reset, `cur_state` is 0 (active), `cur_rate` is 0, `tx_os` is 0 (nothing to send), and `rate_strobe`, `chg_done` and `chg_fail` are low.
- R2: A `start` pulse is accepted only in the active state with `target_rate` different from `cur_rate`. A `start` with equal rates, or a `start` outside the active state, changes neither state, rate nor transmitted fields.
- R3: After an accepted start, the state is 1 (old-rate lock). The block sends TS1 (`tx_os`=1) with `tx_spd_chg`=1 and `tx_rate_id` equal to the target. It moves to state 2 only after 8 consecutive valid received sets that meet all of these: TS1 (`rx_is_ts2`=0), speed-change bit set, rate ID at least the target, lane locked. A valid set that fails this test restarts the count; a cycle without `rx_valid` keeps the count.
- R4: In state 2 (old-rate config) the block sends TS2 (`tx_os`=2) with `tx_spd_chg`=1 and `tx_auto` equal to `up_role`. It moves to state 3 after 8 consecutive valid TS2 that carry the speed-change bit and a rate ID at least the target. The change is marked autonomous if `up_role` is 1, or if the partner's autonomous bit is set on the set that completes the count.
- R5: In state 3 (switch) the block sends EIOS (`tx_os`=3). When `eidle_done` is high, the next cycle shows state 4, `cur_rate` equal to the target, and a one-cycle `rate_strobe`.
- R6: In state 4 (new-rate lock) the block sends EIEOS (`tx_os`=4) while `lane_locked` is low, and TS1 otherwise. `tx_spd_chg` and `tx_auto` are 0 and `tx_rate_id` is the new rate. It advances after 8 consecutive valid TS1 with the speed-change bit clear, the lane locked, and `rx_eq_ctl` equal to the transmitted `tx_eq_ctl`.
- R7: Equalization is needed when the new rate index is 2 or higher (8 GT/s and up) and that rate has not been equalized since reset. The top index is exempt when SKIP_TOP_EQ is 1. In that case state 4 sends `tx_eq_ctl`=1 and then goes to state 5 (equalize, TS1 with `tx_eq_ctl`=1). On `eq_done` the block records the rate as equalized and returns to state 4 with `tx_eq_ctl`=0.
- R8: A change to a rate already equalized since reset takes no detour: state 4 goes straight to state 6.
- R9: In state 6 (new-rate config) the block sends TS2 with both change bits 0. After 8 consecutive valid TS2 with the speed-change bit clear, it goes to state 7 (settle, nothing sent) for one cycle. It then returns to state 0 with a one-cycle `chg_done` and `chg_auto` set as defined in R4.
- R10: If any recovery substate lasts TIMEOUT_CYCLES cycles without advancing, the block returns to state 0, restores the rate held before the start, and pulses `chg_fail`. It also pulses `rate_strobe` if the rate had already switched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| target_rate | input | RW | Wanted rate index (0 = slowest) |
| start | input | 1 | Request a rate change |
| up_role | input | 1 | 1 when this end plays the upstream role |
| rx_valid | input | 1 | A decoded training set is present this cycle |
| rx_is_ts2 | input | 1 | Received set type: 0 = TS1, 1 = TS2 |
| rx_spd_chg | input | 1 | Received speed-change bit |
| rx_auto | input | 1 | Received autonomous-change bit |
| rx_rate_id | input | RW | Received rate ID field |
| rx_eq_ctl | input | 1 | Received equalization-control bit |
| lane_locked | input | 1 | Lanes hold symbol lock |
| eidle_done | input | 1 | Electrical idle entered, rate may switch |
| eq_done | input | 1 | Equalization finished |
| tx_os | output | 3 | Set to send: 0 none, 1 TS1, 2 TS2, 3 EIOS, 4 EIEOS |
| tx_spd_chg | output | 1 | Speed-change bit to send |
| tx_auto | output | 1 | Autonomous bit to send |
| tx_rate_id | output | RW | Rate ID to send |
| tx_eq_ctl | output | 1 | Equalization-control bit to send |
| rate_strobe | output | 1 | One-cycle pulse when `cur_rate` changes |
| chg_done | output | 1 | One-cycle pulse on a completed change |
| chg_fail | output | 1 | One-cycle pulse on a timed-out change |
| chg_auto | output | 1 | Autonomous tag, valid with `chg_done` |
| cur_rate | output | RW | Rate the lanes run at |
| cur_state | output | 3 | Current substate code |

## Verification
The assertions watch, on every cycle, the invariants that tie the substates together:
- a rate strobe always means the rate really moved;
- leaving the switch substate carries the strobe and the target rate;
- completion follows the settle substate;
- failure leaves the old rate in place;
- the equalized ledger never forgets a rate;
- the match and dwell counters stay in range.

Only the bench scenarios can show the full ordered-set sequence, which depends on the history of earlier changes: whether a detour is taken, the top-rate exemption, and the autonomous tag. The same holds for the restart of the match count on a stray set, for ignored requests, and for the exact cycle at which a stalled substate gives up.

// File: rtl/rrs_pkg.sv
// Shared types for the rate-change sequencer.
// Assumes: state and ordered-set codes are visible at the ports, so
// their numeric values are fixed here and must not be reordered.
package rrs_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_LOCK_OLD = 3'd1,
        ST_CFG_OLD  = 3'd2,
        ST_SWITCH   = 3'd3,
        ST_LOCK_NEW = 3'd4,
        ST_EQUALIZE = 3'd5,
        ST_CFG_NEW  = 3'd6,
        ST_SETTLE   = 3'd7
    } rec_state_e;

    typedef enum logic [2:0] {
        OS_NONE  = 3'd0,
        OS_TS1   = 3'd1,
        OS_TS2   = 3'd2,
        OS_EIOS  = 3'd3,
        OS_EIEOS = 3'd4
    } os_kind_e;

endpackage

// File: rtl/rrs_match_count.sv
// Counts consecutive matching received training sets.
// Does: raises hit on the set that completes MATCH_COUNT matches in a row.
// Assumes: clr is asserted on every substate change; a valid set that does
// not match restarts the run, an idle cycle leaves it untouched.
module rrs_match_count #(
    parameter int MATCH_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic valid,
    input  logic match,
    output logic hit
);
    localparam int CW = $clog2(MATCH_COUNT + 1);

    logic [CW-1:0] cnt_q;

    // completion when the last needed match arrives
    assign hit = valid && match && (cnt_q == CW'(MATCH_COUNT - 1));

    // run-length counter of matching sets
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (valid) begin
            if (!match || hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the run never reaches the limit without being consumed
    p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MATCH_COUNT));

endmodule

// File: rtl/rrs_dwell_timer.sv
// Measures how long the sequencer sits in one recovery substate.
// Does: raises expire in the LIMIT-th cycle of an uninterrupted dwell.
// Assumes: clr on every substate change, run low while the link is active.
module rrs_dwell_timer #(
    parameter int LIMIT = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    // limit reached in the current cycle
    assign expire = run && (cnt_q == TW'(LIMIT - 1));

    // dwell cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: the dwell count stays below the limit
    p_dwell_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TW'(LIMIT));

endmodule

// File: rtl/rrs_eq_ledger.sv
// Remembers which 128b/130b rates have been equalized since reset.
// Does: answers whether a given rate still needs the equalization detour.
// Assumes: rates below FIRST_EQ_RATE never need it; the top rate is exempt
// when SKIP_TOP is 1.
module rrs_eq_ledger #(
    parameter int NUM_RATES     = 4,
    parameter int FIRST_EQ_RATE = 2,
    parameter bit SKIP_TOP      = 1'b1,
    localparam int RW           = $clog2(NUM_RATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mark,
    input  logic [RW-1:0] mark_rate,
    input  logic [RW-1:0] query_rate,
    output logic          need
);
    logic [NUM_RATES-1:0] eligible;
    logic [NUM_RATES-1:0] done_q;
    logic [NUM_RATES-1:0] set_vec;

    // per-rate eligibility, fixed by parameters
    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        if (r >= FIRST_EQ_RATE && !(SKIP_TOP && r == NUM_RATES - 1)) begin : g_eq
            assign eligible[r] = 1'b1;
        end else begin : g_plain
            assign eligible[r] = 1'b0;
        end
        assign set_vec[r] = mark && (mark_rate == RW'(r)) && eligible[r];
    end

    // lookup of the queried rate
    assign need = eligible[query_rate] && !done_q[query_rate];

    // sticky equalized flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            done_q <= done_q | set_vec;
        end
    end

    // R7: a rate once equalized stays recorded until reset
    p_ledger_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_q) & ~done_q) == '0);

endmodule

// File: rtl/rate_recovery_seq.sv
// Recovery substate sequencer for a link data-rate change.
// Does: walks active -> old-rate lock/config -> switch -> new-rate lock
// (with an optional equalization detour) -> new-rate config -> settle ->
// active, and selects the ordered set and control bits to transmit.
// Assumes: received fields are already decoded and qualified by rx_valid;
// rate index 0 is the slowest and rates >= FIRST_EQ_RATE use 128b/130b.
module rate_recovery_seq
    import rrs_pkg::*;
#(
    parameter int NUM_RATES      = 4,
    parameter int MATCH_COUNT    = 8,
    parameter int TIMEOUT_CYCLES = 6_000_000,
    parameter int FIRST_EQ_RATE  = 2,
    parameter bit SKIP_TOP_EQ    = 1'b1,
    localparam int RW            = $clog2(NUM_RATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] target_rate,
    input  logic          start,
    input  logic          up_role,
    input  logic          rx_valid,
    input  logic          rx_is_ts2,
    input  logic          rx_spd_chg,
    input  logic          rx_auto,
    input  logic [RW-1:0] rx_rate_id,
    input  logic          rx_eq_ctl,
    input  logic          lane_locked,
    input  logic          eidle_done,
    input  logic          eq_done,
    output logic [2:0]    tx_os,
    output logic          tx_spd_chg,
    output logic          tx_auto,
    output logic [RW-1:0] tx_rate_id,
    output logic          tx_eq_ctl,
    output logic          rate_strobe,
    output logic          chg_done,
    output logic          chg_fail,
    output logic          chg_auto,
    output logic [RW-1:0] cur_rate,
    output logic [2:0]    cur_state
);
    rec_state_e    state_q, state_d;
    logic [RW-1:0] cur_rate_q, cur_rate_d;
    logic [RW-1:0] tgt_q, tgt_d;
    logic [RW-1:0] old_q, old_d;
    logic          eq_pend_q, eq_pend_d;
    logic          auto_q, auto_d;
    logic          strobe_q, strobe_d;
    logic          done_q, done_d;
    logic          fail_q, fail_d;

    logic          set_match;
    logic          hit;
    logic          expire;
    logic          eq_need;
    logic          mark;
    logic          step;
    os_kind_e      tx_kind;

    assign step = (state_d != state_q);

    // acceptance test for the received set in the current substate
    always_comb begin
        set_match = 1'b0;
        unique case (state_q)
            ST_LOCK_OLD: set_match = lane_locked && !rx_is_ts2 && rx_spd_chg
                                     && (rx_rate_id >= tgt_q);
            ST_CFG_OLD:  set_match = rx_is_ts2 && rx_spd_chg
                                     && (rx_rate_id >= tgt_q);
            ST_LOCK_NEW: set_match = lane_locked && !rx_is_ts2 && !rx_spd_chg
                                     && (rx_eq_ctl == eq_pend_q);
            ST_CFG_NEW:  set_match = rx_is_ts2 && !rx_spd_chg;
            default:     set_match = 1'b0;
        endcase
    end

    rrs_match_count #(
        .MATCH_COUNT(MATCH_COUNT)
    ) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step),
        .valid (rx_valid),
        .match (set_match),
        .hit   (hit)
    );

    rrs_dwell_timer #(
        .LIMIT(TIMEOUT_CYCLES)
    ) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (step),
        .run    (state_q != ST_ACTIVE),
        .expire (expire)
    );

    rrs_eq_ledger #(
        .NUM_RATES     (NUM_RATES),
        .FIRST_EQ_RATE (FIRST_EQ_RATE),
        .SKIP_TOP      (SKIP_TOP_EQ)
    ) u_ledger (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark       (mark),
        .mark_rate  (cur_rate_q),
        .query_rate (tgt_q),
        .need       (eq_need)
    );

    // substate transitions, rate switch and result pulses
    always_comb begin
        state_d    = state_q;
        cur_rate_d = cur_rate_q;
        tgt_d      = tgt_q;
        old_d      = old_q;
        eq_pend_d  = eq_pend_q;
        auto_d     = auto_q;
        strobe_d   = 1'b0;
        done_d     = 1'b0;
        fail_d     = 1'b0;
        mark       = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                if (start && (target_rate != cur_rate_q)) begin
                    state_d = ST_LOCK_OLD;
                    tgt_d   = target_rate;
                    old_d   = cur_rate_q;
                    auto_d  = 1'b0;
                end
            end
            ST_LOCK_OLD: if (hit) state_d = ST_CFG_OLD;
            ST_CFG_OLD: begin
                if (hit) begin
                    state_d = ST_SWITCH;
                    auto_d  = up_role | rx_auto;
                end
            end
            ST_SWITCH: begin
                if (eidle_done) begin
                    state_d    = ST_LOCK_NEW;
                    cur_rate_d = tgt_q;
                    strobe_d   = 1'b1;
                    eq_pend_d  = eq_need;
                end
            end
            ST_LOCK_NEW: if (hit) state_d = eq_pend_q ? ST_EQUALIZE : ST_CFG_NEW;
            ST_EQUALIZE: begin
                if (eq_done) begin
                    state_d   = ST_LOCK_NEW;
                    eq_pend_d = 1'b0;
                    mark      = 1'b1;
                end
            end
            ST_CFG_NEW: if (hit) state_d = ST_SETTLE;
            ST_SETTLE: begin
                state_d = ST_ACTIVE;
                done_d  = 1'b1;
            end
            default: state_d = ST_ACTIVE;
        endcase
        if (expire && (state_d == state_q)) begin
            state_d    = ST_ACTIVE;
            cur_rate_d = old_q;
            strobe_d   = (cur_rate_q != old_q);
            eq_pend_d  = 1'b0;
            fail_d     = 1'b1;
        end
    end

    // state and context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_ACTIVE;
            cur_rate_q <= '0;
            tgt_q      <= '0;
            old_q      <= '0;
            eq_pend_q  <= 1'b0;
            auto_q     <= 1'b0;
            strobe_q   <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            cur_rate_q <= cur_rate_d;
            tgt_q      <= tgt_d;
            old_q      <= old_d;
            eq_pend_q  <= eq_pend_d;
            auto_q     <= auto_d;
            strobe_q   <= strobe_d;
            done_q     <= done_d;
            fail_q     <= fail_d;
        end
    end

    // ordered set and field selection per substate
    always_comb begin
        tx_kind    = OS_NONE;
        tx_spd_chg = 1'b0;
        tx_auto    = 1'b0;
        tx_eq_ctl  = 1'b0;
        tx_rate_id = cur_rate_q;
        unique case (state_q)
            ST_LOCK_OLD: begin
                tx_kind    = OS_TS1;
                tx_spd_chg = 1'b1;
                tx_rate_id = tgt_q;
            end
            ST_CFG_OLD: begin
                tx_kind    = OS_TS2;
                tx_spd_chg = 1'b1;
                tx_auto    = up_role;
                tx_rate_id = tgt_q;
            end
            ST_SWITCH: begin
                tx_kind    = OS_EIOS;
                tx_rate_id = tgt_q;
            end
            ST_LOCK_NEW: begin
                tx_kind   = lane_locked ? OS_TS1 : OS_EIEOS;
                tx_eq_ctl = eq_pend_q;
            end
            ST_EQUALIZE: begin
                tx_kind   = OS_TS1;
                tx_eq_ctl = 1'b1;
            end
            ST_CFG_NEW: tx_kind = OS_TS2;
            default:    tx_kind = OS_NONE;
        endcase
    end

    assign tx_os       = tx_kind;
    assign rate_strobe = strobe_q;
    assign chg_done    = done_q;
    assign chg_fail    = fail_q;
    assign chg_auto    = auto_q;
    assign cur_rate    = cur_rate_q;
    assign cur_state   = state_q;

    // R5: leaving the switch substate carries the strobe and the new rate
    p_switch_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK_NEW && $past(state_q) == ST_SWITCH)
        |-> (strobe_q && cur_rate_q == tgt_q));

    // R5: a strobe always reports a real rate movement
    p_strobe_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (cur_rate_q != $past(cur_rate_q)));

    // R2: the rate holds while the link stays active
    p_active_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && $past(state_q) == ST_ACTIVE)
        |-> $stable(cur_rate_q));

    // R9: completion only follows the settle substate
    p_done_after_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(state_q) == ST_SETTLE && state_q == ST_ACTIVE));

    // R9: success and failure never coincide
    p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && fail_q));

    // R10: failure lands in active at the pre-change rate
    p_fail_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q |-> (state_q == ST_ACTIVE && cur_rate_q == old_q));

endmodule

// File: tb/sim_rate_recovery_seq.sv
`timescale 1ns/1ps
module sim_rate_recovery_seq;
    localparam int TMO = 300;

    typedef struct {
        int    kind;   // 0 rate strobe, 1 done, 2 fail
        int    val;    // new rate, auto tag, or restored rate
        string req;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] target_rate = '0;
    logic       start = 1'b0, up_role = 1'b0;
    logic       rx_valid = 1'b0, rx_is_ts2 = 1'b0, rx_spd_chg = 1'b0;
    logic       rx_auto = 1'b0, rx_eq_ctl = 1'b0;
    logic [1:0] rx_rate_id = '0;
    logic       lane_locked = 1'b1, eidle_done = 1'b0, eq_done = 1'b0;
    logic [2:0] tx_os, cur_state;
    logic       tx_spd_chg, tx_auto, tx_eq_ctl;
    logic [1:0] tx_rate_id, cur_rate;
    logic       rate_strobe, chg_done, chg_fail, chg_auto;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    bit  partner_auto = 1'b0;
    ev_t evq[$];

    always #5 clk = ~clk;

    rate_recovery_seq #(.TIMEOUT_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .target_rate(target_rate), .start(start),
        .up_role(up_role), .rx_valid(rx_valid), .rx_is_ts2(rx_is_ts2),
        .rx_spd_chg(rx_spd_chg), .rx_auto(rx_auto), .rx_rate_id(rx_rate_id),
        .rx_eq_ctl(rx_eq_ctl), .lane_locked(lane_locked),
        .eidle_done(eidle_done), .eq_done(eq_done), .tx_os(tx_os),
        .tx_spd_chg(tx_spd_chg), .tx_auto(tx_auto), .tx_rate_id(tx_rate_id),
        .tx_eq_ctl(tx_eq_ctl), .rate_strobe(rate_strobe), .chg_done(chg_done),
        .chg_fail(chg_fail), .chg_auto(chg_auto), .cur_rate(cur_rate),
        .cur_state(cur_state)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_ev(int kind, int val, string req);
        ev_t e;
        e.kind = kind; e.val = val; e.req = req;
        evq.push_back(e);
    endtask

    // monitor: pops the expected result events as the design raises them
    task automatic pop_ev(int kind, int val);
        ev_t e;
        total++;
        if (evq.size() == 0) begin
            bad++;
            $display("FAIL unexpected event kind actual=%0d expected=none", kind);
        end else begin
            e = evq.pop_front();
            if (e.kind != kind || e.val != val) begin
                bad++;
                $display("FAIL %s event kind/val actual=%0d/%0d expected=%0d/%0d",
                         e.req, kind, val, e.kind, e.val);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rate_strobe) pop_ev(0, int'(cur_rate));
            if (chg_done)    pop_ev(1, int'(chg_auto));
            if (chg_fail)    pop_ev(2, int'(cur_rate));
        end
    end

    // driver for n cycles of one received set kind
    task automatic send(int n, bit ts2, bit spd, int rid, bit eq);
        rx_is_ts2 = ts2; rx_spd_chg = spd; rx_rate_id = 2'(rid);
        rx_eq_ctl = eq; rx_auto = partner_auto; rx_valid = 1'b1;
        repeat (n) @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // one full change starting from the active state
    task automatic run_change(int to, bit eq_exp, bit auto_exp);
        target_rate = 2'(to); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3", "state after start", int'(cur_state), 1);
        chk("R3", "tx rate id", int'(tx_rate_id), to);
        send(8, 0, 1, 3, 0);
        chk("R4", "state after lock", int'(cur_state), 2);
        chk("R4", "tx auto", int'(tx_auto), int'(up_role));
        chk("R4", "tx spd", int'(tx_spd_chg), 1);
        send(8, 1, 1, 3, 0);
        chk("R5", "switch os", int'(tx_os), 3);
        push_ev(0, to, "R5");
        eidle_done = 1'b1; @(negedge clk); eidle_done = 1'b0;
        chk("R5", "state after switch", int'(cur_state), 4);
        chk("R5", "cur rate", int'(cur_rate), to);
        chk("R7", "eq ctl in new lock", int'(tx_eq_ctl), int'(eq_exp));
        send(8, 0, 0, 0, eq_exp);
        if (eq_exp) begin
            chk("R7", "equalize state", int'(cur_state), 5);
            eq_done = 1'b1; @(negedge clk); eq_done = 1'b0;
            chk("R7", "back to lock", int'(cur_state), 4);
            chk("R7", "eq ctl cleared", int'(tx_eq_ctl), 0);
            send(8, 0, 0, 0, 0);
        end
        chk("R8", "config after lock", int'(cur_state), 6);
        send(8, 1, 0, 0, 0);
        chk("R9", "settle", int'(cur_state), 7);
        push_ev(1, int'(auto_exp), "R9");
        @(negedge clk);
        chk("R9", "back to active", int'(cur_state), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "state", int'(cur_state), 0);
        chk("R1", "rate", int'(cur_rate), 0);
        chk("R1", "tx os", int'(tx_os), 0);
        chk("R1", "pulses", int'({rate_strobe, chg_done, chg_fail}), 0);

        // detailed change 0 -> 1, downstream role, partner not autonomous
        target_rate = 2'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3", "state", int'(cur_state), 1);
        chk("R3", "tx os", int'(tx_os), 1);
        chk("R3", "tx spd", int'(tx_spd_chg), 1);
        chk("R3", "tx rate id", int'(tx_rate_id), 1);
        send(5, 0, 1, 3, 0);
        send(1, 1, 1, 3, 0);           // stray TS2 restarts the run
        send(7, 0, 1, 3, 0);
        chk("R3", "count restarted", int'(cur_state), 1);
        @(negedge clk);                // idle cycle keeps the run
        chk("R3", "idle keeps lock", int'(cur_state), 1);
        send(1, 0, 1, 3, 0);
        chk("R3", "lock complete", int'(cur_state), 2);
        chk("R4", "tx os", int'(tx_os), 2);
        chk("R4", "tx auto downstream", int'(tx_auto), 0);
        send(8, 1, 1, 3, 0);
        chk("R5", "switch state", int'(cur_state), 3);
        chk("R5", "rate held in switch", int'(cur_rate), 0);
        lane_locked = 1'b0;
        push_ev(0, 1, "R5");
        eidle_done = 1'b1; @(negedge clk); eidle_done = 1'b0;
        chk("R5", "new lock state", int'(cur_state), 4);
        chk("R6", "eieos while unlocked", int'(tx_os), 4);
        lane_locked = 1'b1; #1;
        chk("R6", "ts1 when locked", int'(tx_os), 1);
        chk("R6", "spd clear", int'(tx_spd_chg), 0);
        chk("R6", "auto clear", int'(tx_auto), 0);
        chk("R6", "rate id new", int'(tx_rate_id), 1);
        chk("R7", "no eq at rate 1", int'(tx_eq_ctl), 0);
        send(8, 0, 0, 0, 0);
        chk("R6", "config state", int'(cur_state), 6);
        chk("R9", "tx ts2", int'(tx_os), 2);
        chk("R9", "tx spd", int'(tx_spd_chg), 0);
        send(8, 1, 0, 0, 0);
        chk("R9", "settle", int'(cur_state), 7);
        chk("R9", "settle sends none", int'(tx_os), 0);
        push_ev(1, 0, "R9");
        @(negedge clk);
        chk("R9", "active", int'(cur_state), 0);

        // R2: same-rate request ignored
        target_rate = 2'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2", "same rate ignored", int'(cur_state), 0);
        chk("R2", "tx none", int'(tx_os), 0);

        // R7: first entry to 8 GT/s, upstream role takes the detour
        up_role = 1'b1;
        run_change(2, 1'b1, 1'b1);
        // R7: top rate exempt; partner autonomous bit tags the change
        up_role = 1'b0; partner_auto = 1'b1;
        run_change(3, 1'b0, 1'b1);
        // R8: back to an equalized rate, no detour
        partner_auto = 1'b0;
        run_change(2, 1'b0, 1'b0);

        // R10: stall after the switch; R2: start while busy ignored
        target_rate = 2'd0; start = 1'b1;
        @(negedge clk);
        target_rate = 2'd1;
        @(negedge clk); start = 1'b0;
        chk("R2", "busy start ignored", int'(tx_rate_id), 0);
        send(8, 0, 1, 3, 0);
        send(8, 1, 1, 3, 0);
        push_ev(0, 0, "R5");
        eidle_done = 1'b1; @(negedge clk); eidle_done = 1'b0;
        chk("R10", "stalled lock", int'(cur_state), 4);
        push_ev(0, 2, "R10");
        push_ev(2, 2, "R10");
        repeat (TMO - 1) @(negedge clk);
        chk("R10", "still waiting", int'(cur_state), 4);
        @(negedge clk);
        chk("R10", "gave up", int'(cur_state), 0);
        chk("R10", "rate restored", int'(cur_rate), 2);
        repeat (3) @(negedge clk);

        chk("R9", "events left over", evq.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule